// File: doc/BRIEF.md
# Single-Cycle-Per-Bit Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands and produces a 2*WIDTH-bit product, retiring one multiplier bit on every clock. The multiplicand and the multiplier are written over a shared data bus with two separate load strobes. A start pulse then launches the run. Each run cycle adds the multiplicand to the upper product half when the current low multiplier bit is set. The sum, with its carry-out as the new top bit, is shifted right one place into the upper half and the lower half in the same cycle, so no separate carry flip-flop is needed.

A two-state controller (idle and run) drives the datapath. A down counter is loaded with WIDTH-1 at start and is decremented on each run cycle. The exit decision uses the counter value from before the decrement, so a run always lasts exactly WIDTH cycles. The product halves are exposed directly. The multiplier is shifted out of the lower half from its least significant bit upward, and product bits fill the vacated top of the lower half.

Top module: `shift_add_mul`

## Requirements
- R1: While rst_ni is low and after its release, busy_o and done_o are 0 and product_o is 0.
- R2: In idle, load_mplier_i copies data_i into the multiplier register, which shows on product_o[WIDTH-1:0] after the clock edge. load_mcand_i copies data_i into the multiplicand register.
- R3: A go_i seen high in idle makes busy_o rise after that edge. busy_o then stays high for exactly WIDTH cycles.
- R4: At the edge where busy_o falls, product_o equals the unsigned product of the two loaded operands. done_o is high for exactly that one following cycle.
- R5: The carry-out of each addition is kept as the top bit of the shifted sum, so all-ones operands give the full product with no lost bit.
- R6: go_i while busy_o is high is ignored: the run length and the result do not change.
- R7: Both load strobes are ignored while busy_o is high. The running product is unaffected, and a later run still uses the earlier multiplicand.
- R8: In idle, product_o holds its value until go_i or load_mplier_i. load_mcand_i does not change product_o.
- R9: An operand loaded in the same cycle as go_i is the one used by that run.
- R10: The upper product half is cleared at start, so the result of an earlier run does not leak into the next product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a multiplication (only in idle) |
| load_mcand_i | input | 1 | Write data_i to the multiplicand (only in idle) |
| load_mplier_i | input | 1 | Write data_i to the multiplier (only in idle) |
| data_i | input | WIDTH | Operand bus |
| product_o | output | 2*WIDTH | Upper half followed by lower half of the product register |
| busy_o | output | 1 | High while a run is active |
| done_o | output | 1 | One-cycle pulse after the last run cycle |

## Verification
The hardest situation to reach is a disturbance in the middle of a run. This means a start pulse or an operand load arriving while the counter is partway down. From the ports, a missed case only shows as a changed run length or a corrupted sum. The bench therefore aims these strobes at a fixed mid-run cycle with junk data on the bus. It then checks the run length and the product, and starts a second run that reloads only the multiplier, which shows whether the multiplicand was overwritten. Random operands with a fixed seed are mixed with all-ones, zero and same-cycle load-and-start cases.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic idle_o,
  output logic start_o,
  output logic step_o,
  output logic done_o
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(WIDTH - 1);

  mul_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            last;
  logic            done_q;

  assign idle_o  = (state_q == ST_IDLE);
  assign step_o  = (state_q == ST_RUN);
  assign start_o = idle_o && go_i;
  assign last    = (cnt_q == '0);
  assign done_o  = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i) state_d = ST_RUN;
      ST_RUN:  if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_o && last;
      if (start_o)     cnt_q <= CNT_INIT;
      else if (step_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: counter starts at WIDTH-1 after a start
  a_r3_cnt_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (cnt_q == CNT_INIT) && (state_q == ST_RUN));
  // R3: run continues while counter nonzero, counting down
  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last) |=> (state_q == ST_RUN) && (cnt_q == $past(cnt_q) - 1'b1));
  // R4: leaving run yields a done pulse in idle
  a_r4_exit_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last) |=> (done_o && idle_o));
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: go during run does not restart the counter
  a_r6_go_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && go_i && !last) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mul_step.sv
module mul_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH:0] sum;

  // adder feeding shifter: carry-out lands in the top bit of A
  assign sum = {1'b0, a_i} + (q_i[0] ? {1'b0, b_i} : '0);
  assign a_o = sum[WIDTH:1];
  assign q_o = {sum[0], q_i[WIDTH-1:1]};
endmodule

// File: rtl/mul_regs.sv
module mul_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             load_b_i,
  input  logic             load_q_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] a_q, b_q, q_q;
  logic [WIDTH-1:0] a_nx, q_nx;
  logic             ld_b, ld_q;

  assign ld_b = load_b_i && idle_i;
  assign ld_q = load_q_i && idle_i;

  mul_step #(.WIDTH(WIDTH)) u_step (
    .a_i (a_q),
    .b_i (b_q),
    .q_i (q_q),
    .a_o (a_nx),
    .q_o (q_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      q_q <= '0;
    end else begin
      if (ld_b) b_q <= data_i;
      if (start_i) a_q <= '0;
      else if (step_i) a_q <= a_nx;
      if (ld_q) q_q <= data_i;
      else if (step_i) q_q <= q_nx;
    end
  end

  assign product_o = {a_q, q_q};

  // R7: multiplicand frozen during a run
  a_r7_mcand_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(b_q));
  // R8: product holds in idle without go or multiplier load
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !start_i && !load_q_i) |=> $stable(product_o));
  // R10: upper half cleared by start
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (a_q == '0));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               load_mcand_i,
  input  logic               load_mplier_i,
  input  logic [WIDTH-1:0]   data_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               busy_o,
  output logic               done_o
);
  logic idle, start, step;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_i),
    .idle_o  (idle),
    .start_o (start),
    .step_o  (step),
    .done_o  (done_o)
  );

  mul_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (idle),
    .start_i   (start),
    .step_i    (step),
    .load_b_i  (load_mcand_i),
    .load_q_i  (load_mplier_i),
    .data_i    (data_i),
    .product_o (product_o)
  );

  assign busy_o = step;

  // R1: done and busy never overlap
  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0, ld_b = 1'b0, ld_q = 1'b0;
  logic [W-1:0]   din = '0;
  logic [2*W-1:0] prod;
  logic           busy, done;
  int             n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .load_mcand_i(ld_b),
    .load_mplier_i(ld_q), .data_i(din), .product_o(prod),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input bit is_b, input logic [W-1:0] v);
    din = v; if (is_b) ld_b = 1'b1; else ld_q = 1'b1;
    @(negedge clk);
    ld_b = 1'b0; ld_q = 1'b0;
  endtask

  // disturb: 0 none, 1 go mid-run, 2 loads mid-run
  task automatic run(input logic [2*W-1:0] exp, input int disturb, input string req);
    int bad = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R3 busy after go", busy, 1);
    for (int i = 1; i < W; i++) begin
      if (i == 2 && disturb == 1) go = 1'b1;
      if (i == 2 && disturb == 2) begin din = '1; ld_b = 1'b1; ld_q = 1'b1; end
      @(negedge clk);
      go = 1'b0; ld_b = 1'b0; ld_q = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0) bad++;
    end
    chk("R3 busy held WIDTH cycles", bad, 0);
    @(negedge clk);
    chk({req, " busy falls"}, busy, 0);
    chk({req, " done pulse"}, done, 1);
    chk({req, " product"}, prod, exp);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd771));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 product in reset", prod, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 product after reset", prod, 0);

    // R2 basic load visibility
    load(1'b1, 8'd13);
    chk("R2 mcand load keeps product", prod, 0);
    load(1'b0, 8'd11);
    chk("R2 mplier visible", prod[W-1:0], 11);
    run(ref_mul(13, 11), 0, "R4");

    // R5 all ones
    load(1'b1, '1); load(1'b0, '1);
    run(ref_mul('1, '1), 0, "R5");

    // R8 hold, R10 clear of old upper half
    a = prod[2*W-1:W];
    repeat (3) @(negedge clk);
    chk("R8 product hold", prod, ref_mul('1, '1));
    load(1'b1, 8'd0);
    chk("R8 mcand load no effect", prod, ref_mul('1, '1));
    load(1'b0, 8'd0);
    chk("R2 mplier replaces low half", prod, {a, 8'd0});
    run(0, 0, "R10");

    // R6 go mid-run
    load(1'b1, 8'd200); load(1'b0, 8'd57);
    run(ref_mul(200, 57), 1, "R6");

    // R7 loads mid-run, then rerun with only multiplier reloaded
    load(1'b1, 8'd91); load(1'b0, 8'd170);
    run(ref_mul(91, 170), 2, "R7");
    load(1'b0, 8'd3);
    run(ref_mul(91, 3), 0, "R7 old mcand");

    // R9 load multiplier together with go
    load(1'b1, 8'd37);
    din = 8'd129; ld_q = 1'b1;
    run(ref_mul(37, 129), 0, "R9");

    // random runs
    for (int k = 0; k < 24; k++) begin
      a = W'($urandom); b = W'($urandom);
      load(1'b1, a); load(1'b0, b);
      run(ref_mul(a, b), (k % 3 == 0) ? 1 : 0, "R4 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule